// File: doc/BRIEF.md
# Pipelined Burst Cache Data SRAM

This block is a clocked data store for a second-level cache. Each word is 64 bits wide and split into eight byte lanes. An access begins on a rising clock edge where either of two active-low address strobes is low. One strobe belongs to the processor and the other to the cache controller. That edge loads a base address. On later edges, an internal two-bit beat counter produces the addresses, and it moves forward only when the advance input is low. The four-beat group wraps and never carries into the upper address bits. A static select input chooses the beat order: XOR (interleaved) order or linear wrap order.

Reads pass through two register stages, the array output register and the bus output register. Writes are byte-masked and take their data in the same edge as their address. The bus drive enable `dout_oe` is what a pad ring uses to drive or release the shared data wires. It is cut at once by the asynchronous output enable. It is also low during the cycle after a write edge. After a deselect, the bus stays driven for one extra cycle and is then released.

Two state machines control the block. The select machine has states `A_DESEL` and `A_SEL`:
- `A_DESEL -> A_SEL` on a strobe edge with the chip enable low.
- `A_SEL -> A_DESEL` on a strobe edge with the chip enable high.
- Every other edge holds the state.

The bus machine has states `Q_HIZ`, `Q_DRIVE` and `Q_TAIL`:
- Any state goes to `Q_DRIVE` when the previous edge was a read.
- `Q_DRIVE -> Q_TAIL` when the previous edge was neither a read nor a write.
- `Q_DRIVE -> Q_HIZ` after a write.
- `Q_TAIL -> Q_HIZ` otherwise.
- `Q_HIZ` holds otherwise.

Top module: `sync_burst_sram`

## Requirements
- R1: A rising edge with `adsp_n` or `adsc_n` low loads `addr` as the base and accesses it. If both strobes are low, the processor strobe rule applies and the access is a read.
- R2: On edges with both strobes high, the beat counter steps by one (mod 4) only when `adv_n` is low. With `adv_n` high, the same beat is accessed again.
- R3: With `burst_lin` = 0, beat k (0..3) addresses `{base[AW-1:2], base[1:0] ^ k}`.
- R4: With `burst_lin` = 1, beat k addresses `{base[AW-1:2], (base[1:0] + k) mod 4}`. The upper bits never change.
- R5: With `gw_n` high and `bwe_n` low, lane i (`din[8i+7:8i]`) is written exactly when `bw_n[i]` is low. The other lanes keep their contents.
- R6: `gw_n` low writes all eight lanes, whatever `bwe_n` and `bw_n` are.
- R7: No write happens on an edge with `adsp_n` low, or while the chip is deselected.
- R8: `ce_n` is sampled only on strobe edges. It is ignored on advance and hold edges.
- R9: Read data for an address accessed on edge N drives `dout` after edge N+1.
- R10: `oe_n` high forces `dout_oe` low combinationally.
- R11: After the last read, a deselect keeps `dout_oe` high with the held data for one more cycle, then releases the bus.
- R12: `dout_oe` is low in the cycle after a write edge, even if earlier read data was due then.
- R13: After reset, `dout_oe` is low and the chip is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Chip enable, active low, sampled on strobe edges |
| gw_n | input | 1 | Global write (all lanes), active low |
| bwe_n | input | 1 | Byte write qualifier, active low |
| bw_n | input | LANES | Per-lane write enables, active low |
| burst_lin | input | 1 | 0 = interleaved order, 1 = linear order |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | DATA_W | Registered read data |
| dout_oe | output | 1 | Bus drive enable; low means the bus is released |

## Verification
The hardest situation to reach is the bus tail after a deselect. It needs a read on one edge, then a controller-strobe edge with the chip enable high, and then a check of two consecutive cycles. That exact ordering is driven, the tail data is compared against the last beat, and the release is expected one cycle later. A second hard case is a write that follows directly behind a read whose data is still in flight. The bench places a controller write on the very next edge and expects the bus to stay released through both following cycles.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic {
        A_DESEL,
        A_SEL
    } addr_st_t;

    typedef enum logic [1:0] {
        Q_HIZ,
        Q_DRIVE,
        Q_TAIL
    } out_st_t;

    // low two address bits of beat k within a four-beat group
    function automatic logic [1:0] beat_low(input logic [1:0] base,
                                            input logic [1:0] k,
                                            input logic       lin);
        return lin ? (base + k) : (base ^ k);
    endfunction

endpackage

// File: rtl/sbs_addr_ctl.sv
module sbs_addr_ctl
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int LANES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adsp_n,
    input  logic              adsc_n,
    input  logic              adv_n,
    input  logic              ce_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic              burst_lin,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic [LANES-1:0]  lane_we,
    output logic [1:0]        cnt_o
);

    addr_st_t          state, state_nxt;
    logic [ADDR_W-1:0] base_q;
    logic [1:0]        cnt_q, cnt_nxt;
    logic              start, ce_ok, sel_eff, wr_req;

    assign start = !adsp_n || !adsc_n;
    assign ce_ok = !ce_n;
    assign cnt_o = cnt_q;

    always_comb begin
        unique case (state)
            A_DESEL: state_nxt = (start && ce_ok)  ? A_SEL   : A_DESEL;
            A_SEL:   state_nxt = (start && !ce_ok) ? A_DESEL : A_SEL;
            default: state_nxt = A_DESEL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= A_DESEL;
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            state <= state_nxt;
            cnt_q <= cnt_nxt;
            if (start) base_q <= addr;
        end
    end

    always_comb begin
        sel_eff = start ? ce_ok : (state == A_SEL);
        if (start)       cnt_nxt = 2'd0;
        else if (!adv_n) cnt_nxt = cnt_q + 2'd1;
        else             cnt_nxt = cnt_q;
        acc_addr = start ? addr
                         : {base_q[ADDR_W-1:2], beat_low(base_q[1:0], cnt_nxt, burst_lin)};
        wr_req   = !gw_n || (!bwe_n && !(&bw_n));
        wr_stb   = sel_eff && adsp_n && wr_req;
        if (!wr_stb)     lane_we = '0;
        else if (!gw_n)  lane_we = '1;
        else             lane_we = ~bw_n;
        rd_stb   = sel_eff && !wr_stb;
    end

endmodule

// File: rtl/sbs_mem_array.sv
module sbs_mem_array #(
    parameter int ADDR_W = 9,
    parameter int LANE_W = 8,
    parameter int LANES  = 8
) (
    input  logic                    clk,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        lane_we,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    rd_stb,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (lane_we[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
            if (rd_stb)     rd_q      <= mem[addr];
        end

        assign rdata[g*LANE_W +: LANE_W] = rd_q;
    end

endmodule

// File: rtl/sbs_out_ctl.sv
module sbs_out_ctl
    import sbs_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] rdata,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output out_st_t           st_o,
    output logic              wr_q_o
);

    out_st_t           state, state_nxt;
    logic              rd_q, wr_q;
    logic [DATA_W-1:0] dout_q;

    always_comb begin
        unique case (state)
            Q_HIZ:   state_nxt = rd_q ? Q_DRIVE : Q_HIZ;
            Q_DRIVE: state_nxt = rd_q ? Q_DRIVE : (wr_q ? Q_HIZ : Q_TAIL);
            Q_TAIL:  state_nxt = rd_q ? Q_DRIVE : Q_HIZ;
            default: state_nxt = Q_HIZ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= Q_HIZ;
            rd_q   <= 1'b0;
            wr_q   <= 1'b0;
            dout_q <= '0;
        end else begin
            state <= state_nxt;
            rd_q  <= rd_stb;
            wr_q  <= wr_stb;
            if (rd_q) dout_q <= rdata;
        end
    end

    always_comb begin
        dout    = dout_q;
        dout_oe = !oe_n && (state != Q_HIZ) && !wr_q;
        st_o    = state;
        wr_q_o  = wr_q;
    end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 64,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adsp_n,
    input  logic              adsc_n,
    input  logic              adv_n,
    input  logic              ce_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic              burst_lin,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);

    logic [ADDR_W-1:0] acc_addr;
    logic              rd_stb, wr_stb;
    logic [LANES-1:0]  lane_we;
    logic [1:0]        cnt_w;
    logic [DATA_W-1:0] rdata;
    out_st_t           ost_w;
    logic              wr_q_w;

    sbs_addr_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_addr (
        .clk(clk), .rst_n(rst_n), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .adv_n(adv_n), .ce_n(ce_n), .gw_n(gw_n), .bwe_n(bwe_n),
        .bw_n(bw_n), .burst_lin(burst_lin), .addr(addr),
        .acc_addr(acc_addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .lane_we(lane_we), .cnt_o(cnt_w)
    );

    sbs_mem_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_mem (
        .clk(clk), .addr(acc_addr), .lane_we(lane_we), .wdata(din),
        .rd_stb(rd_stb), .rdata(rdata)
    );

    sbs_out_ctl #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .rdata(rdata), .oe_n(oe_n), .dout(dout), .dout_oe(dout_oe),
        .st_o(ost_w), .wr_q_o(wr_q_w)
    );

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker
    import sbs_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       adsp_n,
    input logic       adsc_n,
    input logic       adv_n,
    input logic       oe_n,
    input logic       dout_oe,
    input logic       wr_q,
    input logic [1:0] cnt,
    input out_st_t    ost
);

    assert_adsp_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !adsp_n |=> !wr_q);

    assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adsp_n && adsc_n && adv_n) |=> $stable(cnt));

    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adsp_n && adsc_n && !adv_n) |=> (cnt == $past(cnt) + 2'd1));

    assert_oe_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_oe);

    assert_tail_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ost == Q_TAIL) |=> (ost != Q_TAIL));

    assert_write_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q |-> !dout_oe);

endmodule

bind sync_burst_sram sbs_checker u_chk (
    .clk(clk), .rst_n(rst_n), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .oe_n(oe_n), .dout_oe(dout_oe), .wr_q(wr_q_w),
    .cnt(cnt_w), .ost(ost_w)
);

// File: tb/tb_sync_burst_sram.sv
`timescale 1ns/1ps
module tb_sync_burst_sram;

    localparam int AW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1, ce_n = 1'b1;
    logic          gw_n = 1'b1, bwe_n = 1'b1, burst_lin = 1'b0, oe_n = 1'b0;
    logic [7:0]    bw_n = 8'hFF;
    logic [AW-1:0] addr = '0;
    logic [63:0]   din = '0;
    logic [63:0]   dout;
    logic          dout_oe;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int          due;
        logic        oe;
        logic [63:0] data;
        string       req;
    } exp_t;
    exp_t exq[$];
    exp_t mon_it;

    logic [63:0] refm [0:(1<<AW)-1];

    sync_burst_sram #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .adv_n(adv_n), .ce_n(ce_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
        .burst_lin(burst_lin), .addr(addr), .din(din), .oe_n(oe_n),
        .dout(dout), .dout_oe(dout_oe)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [AW-1:0] faddr(input logic [AW-1:0] b, input int k, input logic lin);
        logic [1:0] kk = 2'(k);
        return {b[AW-1:2], lin ? (b[1:0] + kk) : (b[1:0] ^ kk)};
    endfunction

    task automatic refw(input logic [AW-1:0] a, input logic [63:0] d, input logic [7:0] m);
        for (int i = 0; i < 8; i++)
            if (m[i]) refm[a][i*8 +: 8] = d[i*8 +: 8];
    endtask

    task automatic drv(input logic p, input logic c, input logic v, input logic ce,
                       input logic gw, input logic bwe, input logic [7:0] bw,
                       input logic [AW-1:0] a, input logic [63:0] d,
                       input logic oe, input logic lin);
        @(negedge clk); #1;
        adsp_n = p; adsc_n = c; adv_n = v; ce_n = ce; gw_n = gw; bwe_n = bwe;
        bw_n = bw; addr = a; din = d; oe_n = oe; burst_lin = lin;
    endtask

    task automatic idle();
        drv(1, 1, 1, 0, 1, 1, 8'hFF, '0, '0, 0, 0);
    endtask

    task automatic push_at(input int due, input logic oe, input logic [63:0] d, input string req);
        exp_t it;
        it.due = due; it.oe = oe; it.data = d; it.req = req;
        exq.push_back(it);
    endtask

    task automatic expect_rd(input logic [AW-1:0] a, input logic oe, input string req);
        push_at(cyc + 2, oe, refm[a], req);
    endtask

    // monitor: compare scoreboard head against the bus
    always @(negedge clk) begin
        while (exq.size() > 0 && exq[0].due == cyc) begin
            mon_it = exq.pop_front();
            checks++;
            if (dout_oe !== mon_it.oe || (mon_it.oe && dout !== mon_it.data)) begin
                errors++;
                $display("FAIL %s: cyc %0d oe=%0b data=%h expected oe=%0b data=%h",
                         mon_it.req, cyc, dout_oe, dout, mon_it.oe, mon_it.data);
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 4000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] b2, b4, pa;
        b2 = 9'h012;
        b4 = 9'h105;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (dout_oe !== 1'b0) begin
            errors++;
            $display("FAIL R13: dout_oe=%0b expected 0", dout_oe);
        end

        // interleaved write burst, base low bits = 2
        drv(1, 0, 1, 0, 0, 1, 8'hFF, b2, 64'h1111_2222_3333_4400, 0, 0);
        refw(faddr(b2, 0, 0), 64'h1111_2222_3333_4400, 8'hFF);
        for (int k = 1; k < 4; k++) begin
            drv(1, 1, 0, 0, 0, 1, 8'hFF, '0, 64'h1111_2222_3333_4400 + 64'(k), 0, 0);
            refw(faddr(b2, k, 0), 64'h1111_2222_3333_4400 + 64'(k), 8'hFF);
        end
        idle(); idle();

        // interleaved read burst with stall and ignored chip enable
        drv(0, 1, 1, 0, 1, 1, 8'hFF, b2, '0, 0, 0);
        expect_rd(faddr(b2, 0, 0), 1, "R1 R3 R9 beat0");
        drv(1, 1, 0, 1, 1, 1, 8'hFF, '0, '0, 0, 0);
        expect_rd(faddr(b2, 1, 0), 1, "R3 R8 beat1 ce ignored");
        drv(1, 1, 1, 1, 1, 1, 8'hFF, '0, '0, 0, 0);
        expect_rd(faddr(b2, 1, 0), 1, "R2 stall rereads beat1");
        drv(1, 1, 0, 0, 1, 1, 8'hFF, '0, '0, 0, 0);
        expect_rd(faddr(b2, 2, 0), 1, "R3 beat2");
        drv(1, 1, 0, 0, 1, 1, 8'hFF, '0, '0, 0, 0);
        expect_rd(faddr(b2, 3, 0), 1, "R3 beat3 wrap");
        drv(1, 0, 1, 1, 1, 1, 8'hFF, '0, '0, 0, 0);
        push_at(cyc + 2, 1, refm[faddr(b2, 3, 0)], "R11 tail holds data");
        push_at(cyc + 3, 0, '0, "R11 release after tail");
        idle(); idle(); idle();

        // linear write burst; first beat uses global write over partial lanes
        drv(1, 0, 1, 0, 0, 0, 8'hFE, b4, 64'hA0A1_A2A3_A4A5_A6A7, 0, 1);
        refw(faddr(b4, 0, 1), 64'hA0A1_A2A3_A4A5_A6A7, 8'hFF);
        for (int k = 1; k < 4; k++) begin
            drv(1, 1, 0, 0, 0, 1, 8'hFF, '0, 64'hB000_0000_0000_0000 + 64'(k), 0, 1);
            refw(faddr(b4, k, 1), 64'hB000_0000_0000_0000 + 64'(k), 8'hFF);
        end
        pa = faddr(b4, 2, 1);
        drv(1, 0, 1, 0, 1, 0, 8'hA5, pa, 64'hFFEE_DDCC_BBAA_9988, 0, 1);
        refw(pa, 64'hFFEE_DDCC_BBAA_9988, 8'h5A);
        idle();

        drv(1, 0, 1, 0, 1, 1, 8'hFF, b4, '0, 0, 1);
        expect_rd(faddr(b4, 0, 1), 1, "R4 R6 linear beat0");
        drv(1, 1, 0, 0, 1, 1, 8'hFF, '0, '0, 0, 1);
        expect_rd(faddr(b4, 1, 1), 1, "R4 linear beat1");
        drv(1, 1, 0, 0, 1, 1, 8'hFF, '0, '0, 0, 1);
        expect_rd(faddr(b4, 2, 1), 1, "R5 byte mask lanes 1 3 4 6");
        drv(1, 1, 0, 0, 1, 1, 8'hFF, '0, '0, 0, 1);
        expect_rd(faddr(b4, 3, 1), 1, "R4 linear wrap beat3");
        idle(); idle();

        // writes that must be ignored
        drv(0, 1, 1, 0, 0, 1, 8'hFF, b2, 64'hDEAD_DEAD_DEAD_DEAD, 0, 0);
        expect_rd(b2, 1, "R7 processor strobe edge reads");
        drv(0, 0, 1, 0, 0, 1, 8'hFF, faddr(b2, 1, 0), 64'hDEAD_0000_DEAD_0000, 0, 0);
        expect_rd(faddr(b2, 1, 0), 1, "R1 both strobes give read");
        drv(1, 0, 1, 1, 0, 1, 8'hFF, faddr(b2, 1, 0), 64'hBAD0_BAD0_BAD0_BAD0, 0, 0);
        drv(1, 1, 0, 0, 0, 1, 8'hFF, '0, 64'hBAD1_BAD1_BAD1_BAD1, 0, 0);
        push_at(cyc + 2, 0, '0, "R8 still deselected on advance");
        idle(); idle();
        drv(0, 1, 1, 0, 1, 1, 8'hFF, b2, '0, 0, 0);
        expect_rd(b2, 1, "R7 contents unchanged");
        drv(0, 1, 1, 0, 1, 1, 8'hFF, faddr(b2, 1, 0), '0, 0, 0);
        expect_rd(faddr(b2, 1, 0), 1, "R8 no write while deselected");
        idle();

        // asynchronous output enable
        drv(0, 1, 1, 0, 1, 1, 8'hFF, b2, '0, 0, 0);
        push_at(cyc + 2, 0, '0, "R10 oe_n high releases bus");
        drv(1, 1, 1, 0, 1, 1, 8'hFF, '0, '0, 1, 0);
        expect_rd(b2, 1, "R10 bus returns with oe_n low");
        idle(); idle();

        // write directly behind a read
        drv(0, 1, 1, 0, 1, 1, 8'hFF, b2, '0, 0, 0);
        push_at(cyc + 2, 0, '0, "R12 read data suppressed by write");
        drv(1, 0, 1, 0, 0, 1, 8'hFF, 9'h020, 64'h0F0E_0D0C_0B0A_0908, 0, 0);
        refw(9'h020, 64'h0F0E_0D0C_0B0A_0908, 8'hFF);
        push_at(cyc + 2, 0, '0, "R12 released after write");
        drv(0, 1, 1, 0, 1, 1, 8'hFF, 9'h020, '0, 0, 0);
        expect_rd(9'h020, 1, "R12 R6 written word reads back");
        repeat (6) idle();

        if (exq.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R9: %0d expected items never compared, expected 0", exq.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule